// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Sequencer

This block sits on the controller side of a three-wire serial link (clock, data, active-low select) to a dual 10-bit voltage DAC. Software-side logic hands it one command at a time over a valid/ready handshake: load channel A, load channel B, stage a channel B value without moving the output, program the reference selection, or move both channels together. The block turns each command into one or two 16-bit words and shifts them out most significant bit first. It generates the serial clock from the system clock, and the half period is set by a programmable divider.

Data changes only while the serial clock is high, and the receiver samples it on the falling edge. The select is framed around the 16 clock pulses with one half period of setup and one of hold. Frames are spaced so that the converter is never updated more often than its minimum update period. A simultaneous update becomes a staging word that carries the channel B code, followed by a channel A word that also transfers the staged value. The speed-mode bit is carried from word to word unless a command explicitly changes it, so the converter's supply current never steps between the two words.

Top module: `dacseq_top`

## Requirements
- R1: After reset the select and serial clock are high, the command input is ready, and the remembered speed mode is slow (0).
- R2: Each frame has exactly 16 falling serial-clock edges while the select is low. The data line holds its value through every falling edge and while the clock is low. The word goes out bit 15 first.
- R3: Address bits (bit 15, bit 12) per op code: write A (0) gives 1,0; write B (1) gives 0,0; stage B (2) gives 0,1; set reference (3) gives 1,1.
- R4: For data writes the 10-bit code sits in bits 11..2 and bits 1..0 are 0. For set reference (op 3), bits 1..0 carry the 2-bit selection and bits 11..2 are 0.
- R5: A both-channels command (op 4) emits two frames: first (0,1) with the channel B code, then (1,0) with the channel A code.
- R6: Bit 14 equals the speed input when the speed-write flag is set at acceptance, and the previous word's speed otherwise. Both frames of op 4 carry the same value.
- R7: Bit 13 equals the power-down configuration input sampled when the command is accepted.
- R8: With half period H (the divider value, 0 treated as 1), each clock-low phase lasts H cycles and the select stays low for 33*H cycles. The select changes only while the clock is high.
- R9: Consecutive select falling edges are at least UPD_CYC system cycles apart.
- R10: Ready is low from the cycle after acceptance until the last frame of the command has finished its inter-frame gap. No frame is active while ready is high.
- R11: Op codes 5 to 7 are accepted, produce no frame and leave the remembered speed mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_op | input | 3 | Operation code (0 A, 1 B, 2 stage B, 3 reference, 4 both) |
| cmd_code_a | input | 10 | Channel A code |
| cmd_code_b | input | 10 | Channel B code |
| cmd_ref | input | 2 | Reference selection for op 3 |
| cmd_spd_we | input | 1 | Apply cmd_spd as new speed mode |
| cmd_spd | input | 1 | Requested speed mode (1 fast) |
| cfg_pdown | input | 1 | Sticky power-down configuration |
| clk_div | input | DIV_W | Serial clock half period in system cycles |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_din | output | 1 | Serial data |
| dac_cs_n | output | 1 | Active-low frame select |

## Verification
The hardest situation to reach is the hand-off inside a both-channels command. The first frame's gap must finish, the second frame must start with the speed bit carried over, and ready must stay low throughout. Spacing must hold at divider values where either the update period or the minimum gap governs. Directed commands cover op 4 at the smallest and largest divider. An invalid op carrying a speed write is followed by a plain write, which shows through the emitted word that the speed mode was kept. Seeded random commands then mix ops, codes, dividers and speed writes, and each decoded frame is compared with a word predicted by a bench model of the speed and power-down bits.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 10;
  localparam int REF_W  = 2;

  typedef enum logic [2:0] {
    OP_WR_A    = 3'd0,
    OP_WR_B    = 3'd1,
    OP_STAGE_B = 3'd2,
    OP_SET_REF = 3'd3,
    OP_BOTH    = 3'd4
  } op_e;

  function automatic logic [WORD_W-1:0] pack_word(input logic hi_addr, input logic lo_addr,
                                                  input logic spd, input logic pd,
                                                  input logic [CODE_W-1:0] code,
                                                  input logic [REF_W-1:0] tail);
    pack_word = {hi_addr, spd, pd, lo_addr, code, tail};
  endfunction
endpackage

// File: rtl/dacseq_cmd.sv
module dacseq_cmd
  import dacseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [CODE_W-1:0] cmd_code_a,
  input  logic [CODE_W-1:0] cmd_code_b,
  input  logic [REF_W-1:0]  cmd_ref,
  input  logic              cmd_spd_we,
  input  logic              cmd_spd,
  input  logic              cfg_pdown,
  input  logic              ser_done,
  output logic              cmd_ready,
  output logic              ser_start,
  output logic [WORD_W-1:0] ser_word
);
  typedef enum logic [1:0] {C_IDLE, C_FIRST, C_LAST} cst_e;

  cst_e              st;
  logic              spd_q;
  logic              spd_use;
  logic              op_ok;
  logic              op_pair;
  logic [WORD_W-1:0] w_first;
  logic [WORD_W-1:0] w_second;
  logic [WORD_W-1:0] next_q;

  always_comb begin
    spd_use  = cmd_spd_we ? cmd_spd : spd_q;
    op_ok    = 1'b1;
    op_pair  = 1'b0;
    w_second = '0;
    case (cmd_op)
      OP_WR_A:    w_first = pack_word(1'b1, 1'b0, spd_use, cfg_pdown, cmd_code_a, '0);
      OP_WR_B:    w_first = pack_word(1'b0, 1'b0, spd_use, cfg_pdown, cmd_code_b, '0);
      OP_STAGE_B: w_first = pack_word(1'b0, 1'b1, spd_use, cfg_pdown, cmd_code_b, '0);
      OP_SET_REF: w_first = pack_word(1'b1, 1'b1, spd_use, cfg_pdown, '0, cmd_ref);
      OP_BOTH: begin
        w_first  = pack_word(1'b0, 1'b1, spd_use, cfg_pdown, cmd_code_b, '0);
        w_second = pack_word(1'b1, 1'b0, spd_use, cfg_pdown, cmd_code_a, '0);
        op_pair  = 1'b1;
      end
      default: begin
        w_first = '0;
        op_ok   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_IDLE;
      spd_q     <= 1'b0;
      ser_start <= 1'b0;
      ser_word  <= '0;
      next_q    <= '0;
    end else begin
      ser_start <= 1'b0;
      case (st)
        C_IDLE: begin
          if (cmd_valid && op_ok) begin
            spd_q     <= spd_use;
            ser_word  <= w_first;
            next_q    <= w_second;
            ser_start <= 1'b1;
            st        <= op_pair ? C_FIRST : C_LAST;
          end
        end
        C_FIRST: begin
          if (ser_done) begin
            ser_word  <= next_q;
            ser_start <= 1'b1;
            st        <= C_LAST;
          end
        end
        default: begin
          if (ser_done) st <= C_IDLE;
        end
      endcase
    end
  end

  assign cmd_ready = (st == C_IDLE);
endmodule

// File: rtl/dacseq_ser.sv
module dacseq_ser
  import dacseq_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int UPD_CYC = 200,
  parameter int GAP_MIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic [DIV_W-1:0]  div,
  output logic              sclk,
  output logic              sdin,
  output logic              cs_n,
  output logic              done
);
  localparam int PH_LAST = 2 * WORD_W;
  localparam int PH_W    = $clog2(PH_LAST + 1);
  localparam int GAP_W   = $clog2(UPD_CYC + GAP_MIN + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} sst_e;

  sst_e              st;
  logic [WORD_W-1:0] sh;
  logic [PH_W-1:0]   ph;
  logic [DIV_W-1:0]  hc;
  logic [DIV_W-1:0]  half_q;
  logic [DIV_W-1:0]  half_n;
  logic [GAP_W-1:0]  gap_q;
  logic [GAP_W-1:0]  gap_n;
  logic [GAP_W-1:0]  gc;
  int                act_len;

  always_comb begin
    half_n  = (div == '0) ? DIV_W'(1) : div;
    act_len = (PH_LAST + 1) * int'(half_n);
    if (act_len + GAP_MIN < UPD_CYC) gap_n = GAP_W'(UPD_CYC - act_len);
    else                             gap_n = GAP_W'(GAP_MIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cs_n   <= 1'b1;
      sclk   <= 1'b1;
      sdin   <= 1'b0;
      sh     <= '0;
      ph     <= '0;
      hc     <= '0;
      half_q <= DIV_W'(1);
      gap_q  <= GAP_W'(GAP_MIN);
      gc     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            cs_n   <= 1'b0;
            sclk   <= 1'b1;
            sh     <= word;
            sdin   <= word[WORD_W-1];
            ph     <= '0;
            hc     <= '0;
            half_q <= half_n;
            gap_q  <= gap_n;
            st     <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (hc == half_q - DIV_W'(1)) begin
            hc <= '0;
            if (ph == PH_W'(PH_LAST)) begin
              cs_n <= 1'b1;
              gc   <= '0;
              st   <= S_GAP;
            end else begin
              ph <= ph + PH_W'(1);
              if (!ph[0]) begin
                sclk <= 1'b0;
              end else begin
                sclk <= 1'b1;
                sh   <= {sh[WORD_W-2:0], 1'b0};
                sdin <= sh[WORD_W-2];
              end
            end
          end else begin
            hc <= hc + DIV_W'(1);
          end
        end
        default: begin
          if (gc == gap_q - GAP_W'(1)) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            gc <= gc + GAP_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dacseq_top.sv
module dacseq_top
  import dacseq_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int UPD_CYC = 200,
  parameter int GAP_MIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [CODE_W-1:0] cmd_code_a,
  input  logic [CODE_W-1:0] cmd_code_b,
  input  logic [REF_W-1:0]  cmd_ref,
  input  logic              cmd_spd_we,
  input  logic              cmd_spd,
  input  logic              cfg_pdown,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              dac_sclk,
  output logic              dac_din,
  output logic              dac_cs_n
);
  logic              ser_start;
  logic              ser_done;
  logic [WORD_W-1:0] ser_word;

  dacseq_cmd u_cmd (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_code_a (cmd_code_a),
    .cmd_code_b (cmd_code_b),
    .cmd_ref    (cmd_ref),
    .cmd_spd_we (cmd_spd_we),
    .cmd_spd    (cmd_spd),
    .cfg_pdown  (cfg_pdown),
    .ser_done   (ser_done),
    .cmd_ready  (cmd_ready),
    .ser_start  (ser_start),
    .ser_word   (ser_word)
  );

  dacseq_ser #(.DIV_W(DIV_W), .UPD_CYC(UPD_CYC), .GAP_MIN(GAP_MIN)) u_ser (
    .clk   (clk),
    .rst   (rst),
    .start (ser_start),
    .word  (ser_word),
    .div   (clk_div),
    .sclk  (dac_sclk),
    .sdin  (dac_din),
    .cs_n  (dac_cs_n),
    .done  (ser_done)
  );
endmodule

// File: rtl/dacseq_chk.sv
module dacseq_chk #(
  parameter int UPD_CYC = 200
) (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic dac_sclk,
  input logic dac_din,
  input logic dac_cs_n
);
  localparam int CNT_W = $clog2(UPD_CYC + 1) + 1;

  logic             cs_d;
  logic [CNT_W-1:0] since_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d       <= 1'b1;
      since_fall <= CNT_W'(UPD_CYC);
    end else begin
      cs_d <= dac_cs_n;
      if (cs_d && !dac_cs_n)                 since_fall <= CNT_W'(1);
      else if (since_fall < CNT_W'(UPD_CYC)) since_fall <= since_fall + CNT_W'(1);
    end
  end

  p_din_low_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!dac_cs_n && !dac_sclk) |=> (dac_sclk || dac_cs_n || $stable(dac_din)));

  p_din_fall_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!dac_cs_n && $fell(dac_sclk)) |-> $stable(dac_din));

  p_cs_edge_clk_high_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_cs_n) |-> dac_sclk);

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    !dac_cs_n |-> !cmd_ready);

  p_frame_spacing_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_cs_n) |-> (since_fall >= CNT_W'(UPD_CYC)));
endmodule

bind dacseq_top dacseq_chk #(.UPD_CYC(UPD_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .dac_sclk  (dac_sclk),
  .dac_din   (dac_din),
  .dac_cs_n  (dac_cs_n)
);

// File: tb/tb_dacseq_top.sv
`timescale 1ns/1ps
module tb_dacseq_top;
  localparam int DIV_W = 4;
  localparam int UPD   = 200;
  localparam int GMIN  = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [2:0]       cmd_op = '0;
  logic [9:0]       cmd_code_a = '0;
  logic [9:0]       cmd_code_b = '0;
  logic [1:0]       cmd_ref = '0;
  logic             cmd_spd_we = 1'b0;
  logic             cmd_spd = 1'b0;
  logic             cfg_pdown = 1'b0;
  logic [DIV_W-1:0] clk_div = '0;
  logic             dac_sclk;
  logic             dac_din;
  logic             dac_cs_n;

  always #2 clk = ~clk;

  dacseq_top #(.DIV_W(DIV_W), .UPD_CYC(UPD), .GAP_MIN(GMIN)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_code_a(cmd_code_a), .cmd_code_b(cmd_code_b),
    .cmd_ref(cmd_ref), .cmd_spd_we(cmd_spd_we), .cmd_spd(cmd_spd),
    .cfg_pdown(cfg_pdown), .clk_div(clk_div),
    .dac_sclk(dac_sclk), .dac_din(dac_din), .dac_cs_n(dac_cs_n)
  );

  int          n_tests = 0;
  int          n_fail = 0;
  bit          ended = 0;
  logic [15:0] expq[$];
  string       tagq[$];
  int          exp_half = 1;
  bit          exp_spd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit a15, input bit a12, input bit spd,
                                     input bit pd, input logic [9:0] code,
                                     input logic [1:0] tail);
    return {a15, spd, pd, a12, code, tail};
  endfunction

  // frame monitor
  int          cyc = 0;
  int          last_fall = 0;
  bit          have_fall = 0;
  bit          prev_cs = 1;
  bit          prev_sclk = 1;
  int          nf = 0;
  int          lowlen = 0;
  int          sl_run = 0;
  logic [15:0] bits = '0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (!dac_cs_n && cmd_ready) chk(0, "R10", "ready high during frame", 1, 0);
      if (prev_cs && !dac_cs_n) begin
        if (have_fall) chk(cyc - last_fall >= UPD, "R9", "frame spacing", cyc - last_fall, UPD);
        have_fall = 1;
        last_fall = cyc;
        nf = 0; lowlen = 0; sl_run = 0; bits = '0;
      end
      if (!dac_cs_n) begin
        lowlen++;
        if (prev_sclk && !dac_sclk) begin
          bits = {bits[14:0], dac_din};
          nf++;
        end
        if (!dac_sclk) sl_run++;
        if (!prev_sclk && dac_sclk) begin
          if (sl_run != exp_half) chk(0, "R8", "clock low phase", sl_run, exp_half);
          sl_run = 0;
        end
      end
      if (!prev_cs && dac_cs_n) begin
        chk(nf == 16, "R2", "falling edges per frame", nf, 16);
        chk(lowlen == 33 * exp_half, "R8", "select low length", lowlen, 33 * exp_half);
        if (expq.size() == 0) begin
          chk(0, "R11", "unexpected frame", bits, 0);
        end else begin
          logic [15:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(bits == e, t, "frame word", bits, e);
        end
      end
      prev_cs = dac_cs_n;
      prev_sclk = dac_sclk;
    end
  end

  task automatic issue(input int op, input logic [9:0] a, input logic [9:0] b,
                       input logic [1:0] rsel, input bit swe, input bit s,
                       input bit pd, input int dv, input string tag);
    bit su;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10", "ready before issue", cmd_ready, 1);
    cmd_op = op[2:0]; cmd_code_a = a; cmd_code_b = b; cmd_ref = rsel;
    cmd_spd_we = swe; cmd_spd = s; cfg_pdown = pd; clk_div = dv[DIV_W-1:0];
    exp_half = (dv == 0) ? 1 : dv;
    su = swe ? s : exp_spd;
    case (op)
      0: begin expq.push_back(mk(1, 0, su, pd, a, 2'b00)); tagq.push_back(tag); end
      1: begin expq.push_back(mk(0, 0, su, pd, b, 2'b00)); tagq.push_back(tag); end
      2: begin expq.push_back(mk(0, 1, su, pd, b, 2'b00)); tagq.push_back(tag); end
      3: begin expq.push_back(mk(1, 1, su, pd, 10'd0, rsel)); tagq.push_back(tag); end
      4: begin
        expq.push_back(mk(0, 1, su, pd, b, 2'b00)); tagq.push_back(tag);
        expq.push_back(mk(1, 0, su, pd, a, 2'b00)); tagq.push_back(tag);
      end
      default: ;
    endcase
    if (op <= 4) exp_spd = su;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op <= 4) begin
      chk(cmd_ready == 1'b0, "R10", "ready drops after accept", cmd_ready, 0);
      while (!cmd_ready) @(negedge clk);
    end else begin
      chk(cmd_ready == 1'b1, "R11", "ready stays high for invalid op", cmd_ready, 1);
      repeat (40) @(negedge clk);
      chk(dac_cs_n == 1'b1, "R11", "no frame for invalid op", dac_cs_n, 1);
    end
    chk(expq.size() == 0, tag, "all frames emitted", expq.size(), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!ended) begin
      ended = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dac_cs_n == 1'b1, "R1", "select after reset", dac_cs_n, 1);
    chk(dac_sclk == 1'b1, "R1", "clock after reset", dac_sclk, 1);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);

    issue(0, 10'h3FF, 10'h000, 2'b00, 0, 0, 0, 1, "R1");
    issue(1, 10'h000, 10'h155, 2'b00, 0, 0, 0, 0, "R3");
    issue(2, 10'h000, 10'h2AA, 2'b00, 1, 1, 0, 3, "R6");
    issue(0, 10'h001, 10'h000, 2'b00, 0, 0, 0, 2, "R6");
    issue(3, 10'h3FF, 10'h3FF, 2'b10, 0, 0, 1, 1, "R4");
    issue(1, 10'h000, 10'h200, 2'b11, 0, 0, 1, 4, "R7");
    issue(4, 10'h200, 10'h3FF, 2'b00, 0, 0, 0, 0, "R5");
    issue(6, 10'h123, 10'h321, 2'b00, 1, 0, 0, 1, "R11");
    issue(1, 10'h000, 10'h0F0, 2'b00, 0, 0, 0, 1, "R11");
    issue(4, 10'h155, 10'h0AA, 2'b00, 1, 0, 1, 15, "R9");
    issue(3, 10'h000, 10'h000, 2'b01, 0, 0, 0, 7, "R4");

    for (int i = 0; i < 30; i++) begin
      int op;
      op = $urandom_range(0, 5);
      issue(op, 10'($urandom), 10'($urandom), 2'($urandom), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            $urandom_range(0, 7), (op == 4) ? "R5" : (op == 5) ? "R11" : "R3");
    end

    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule